// File: doc/BRIEF.md
# Spare Row and Spare Column Address Remapper

This block sits between a memory controller and a storage array that has spare rows and one spare data column. It steers accesses around manufacturing defects. A small table of repair entries is held in fuse registers. Each entry has a row address and a valid flag. On every read or write request, the incoming row address is compared against every entry. A valid match fires the spare wordline that belongs to that entry and blocks the normal row decoder. When nothing matches, the normal decoder raises the one-hot wordline for the row address. All wordlines are registered. They follow the request by one clock.

The column side is combinational. A fuse vector with one bit per data column marks the bad column and every column above it. Write data at and above the bad column moves up by one position, so the top bit lands in the spare column. Read data from the array moves down by the same amount. A word written through a repaired array therefore reads back unchanged. With an all-zero vector there is no shift, the spare column is never written, and its read value has no effect.

Top module: `mem_repair_map`

## Requirements
- R1: With no valid repair entry matching, a read or write request on row address A raises exactly wordline A (index equal to the binary value of A, so 0 is all bits low and 2^AW-1 all bits high) on the clock after the request, and no spare wordline.
- R2: In a cycle with neither read nor write request, all normal and spare wordlines are low on the following clock.
- R3: A request whose row address equals the address of a valid repair entry k raises spare wordline k on the next clock, and every normal wordline stays low.
- R4: A repair entry whose valid flag is clear never matches, even when its address equals the request address; the normal wordline fires instead.
- R5: When several valid entries hold the request address, only the lowest-numbered one raises its spare wordline.
- R6: At most one wordline, normal or spare, is high in any cycle.
- R7: The column fuse vector is thermometer coded: bit i is 1 for every column i at or above the bad column b. On write, array column j takes write bit j for j<b, 0 for j=b, and write bit j-1 for j>b. The spare column (array bit DATA_W) takes the top write bit, and its write enable follows the write request.
- R8: With a repair at column b, read bit i comes from array column i for i<b and from array column i+1 for i>=b. The top read bit comes from the spare column.
- R9: With an all-zero column fuse vector, write data passes to array columns unchanged, the spare column is written with 0 and its write enable stays low, and the spare column's read value has no effect on read data.
- R10: Any word written through the column shift and returned unchanged by the array reads back equal to the written word, for every bad-column position.
- R11: While reset is asserted, all wordlines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read request this cycle |
| wr_req | input | 1 | Write request this cycle |
| row_addr | input | ROW_AW | Requested row |
| rep_addr | input | N_SPARE*ROW_AW | Repair entry addresses, entry k in bits k*ROW_AW upward |
| rep_vld | input | N_SPARE | Repair entry valid flags |
| col_fuse | input | DATA_W | Thermometer-coded bad-column vector |
| wr_data | input | DATA_W | Write word from the controller |
| arr_wdata | output | DATA_W+1 | Write word to the array, top bit is the spare column |
| spare_col_we | output | 1 | Write enable of the spare column |
| arr_rdata | input | DATA_W+1 | Read word from the array, top bit is the spare column |
| rd_data | output | DATA_W | Read word to the controller |
| wl | output | 2**ROW_AW | Registered normal wordlines |
| spare_wl | output | N_SPARE | Registered spare wordlines |

## Verification
A spare-row hit and the normal decode both work on the same request, so they can meet in one cycle. The bench sends requests to addresses that are held by valid entries, by invalid entries and by duplicate entries. On the next clock it checks that exactly the expected single line, normal or spare, is high. A row remap and a column shift can also act in the same write. The bench does row hits while a column repair is active, then judges the column mapping against a model of the shift that is written separately from the RTL, and judges the round trip by loopback.

// File: rtl/mrr_pkg.sv
package mrr_pkg;
  localparam int unsigned ROW_AW_DEF  = 8;
  localparam int unsigned N_SPARE_DEF = 2;
  localparam int unsigned DATA_W_DEF  = 8;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10,
    ACC_BOTH  = 2'b11
  } acc_kind_e;
endpackage

// File: rtl/mrr_row_match.sv
module mrr_row_match #(
  parameter int unsigned AW = 8,
  parameter int unsigned NS = 2
) (
  input  logic [AW-1:0]    addr,
  input  logic [NS*AW-1:0] rep_addr,
  input  logic [NS-1:0]    rep_vld,
  output logic [NS-1:0]    sel,
  output logic             hit
);
  logic [NS-1:0] raw;

  for (genvar k = 0; k < NS; k++) begin : g_cmp
    assign raw[k] = rep_vld[k] && (rep_addr[k*AW +: AW] == addr);
  end

  // lowest-numbered matching entry wins
  always_comb begin
    logic taken;
    taken = 1'b0;
    sel   = '0;
    for (int k = 0; k < NS; k++) begin
      if (raw[k] && !taken) begin
        sel[k] = 1'b1;
        taken  = 1'b1;
      end
    end
  end

  assign hit = |raw;
endmodule

// File: rtl/mrr_row_decoder.sv
module mrr_row_decoder #(
  parameter int unsigned AW = 8
) (
  input  logic [AW-1:0]       addr,
  input  logic                en,
  output logic [(1<<AW)-1:0]  line
);
  localparam int unsigned NL = 1 << AW;

  for (genvar k = 0; k < NL; k++) begin : g_line
    assign line[k] = en && (addr == AW'(k));
  end
endmodule

// File: rtl/mrr_col_shift.sv
module mrr_col_shift #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] fuse,
  input  logic [W-1:0] wdata_in,
  output logic [W:0]   wdata_out,
  input  logic [W:0]   rdata_in,
  output logic [W-1:0] rdata_out
);
  // write direction: shift up from the bad column, bad column gets 0
  for (genvar j = 0; j < W; j++) begin : g_wr
    if (j == 0) begin : g_lo
      assign wdata_out[j] = fuse[j] ? 1'b0 : wdata_in[j];
    end else begin : g_hi
      assign wdata_out[j] = fuse[j] ? (fuse[j-1] ? wdata_in[j-1] : 1'b0)
                                    : wdata_in[j];
    end
  end
  assign wdata_out[W] = fuse[W-1] ? wdata_in[W-1] : 1'b0;

  // read direction: skip the bad column
  for (genvar i = 0; i < W; i++) begin : g_rd
    assign rdata_out[i] = fuse[i] ? rdata_in[i+1] : rdata_in[i];
  end
endmodule

// File: rtl/mem_repair_map.sv
module mem_repair_map
  import mrr_pkg::*;
#(
  parameter int unsigned ROW_AW  = ROW_AW_DEF,
  parameter int unsigned N_SPARE = N_SPARE_DEF,
  parameter int unsigned DATA_W  = DATA_W_DEF
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_req,
  input  logic                        wr_req,
  input  logic [ROW_AW-1:0]           row_addr,
  input  logic [N_SPARE*ROW_AW-1:0]   rep_addr,
  input  logic [N_SPARE-1:0]          rep_vld,
  input  logic [DATA_W-1:0]           col_fuse,
  input  logic [DATA_W-1:0]           wr_data,
  output logic [DATA_W:0]             arr_wdata,
  output logic                        spare_col_we,
  input  logic [DATA_W:0]             arr_rdata,
  output logic [DATA_W-1:0]           rd_data,
  output logic [(1<<ROW_AW)-1:0]      wl,
  output logic [N_SPARE-1:0]          spare_wl
);
  localparam int unsigned NL = 1 << ROW_AW;

  acc_kind_e          kind;
  logic               req;
  logic [N_SPARE-1:0] sel;
  logic               hit;
  logic [NL-1:0]      wl_d, wl_q;
  logic [N_SPARE-1:0] sp_d, sp_q;
  logic               upd_en;

  assign kind = acc_kind_e'({wr_req, rd_req});
  assign req  = (kind != ACC_IDLE);

  mrr_row_match #(.AW(ROW_AW), .NS(N_SPARE)) u_match (
    .addr     (row_addr),
    .rep_addr (rep_addr),
    .rep_vld  (rep_vld),
    .sel      (sel),
    .hit      (hit)
  );

  mrr_row_decoder #(.AW(ROW_AW)) u_dec (
    .addr (row_addr),
    .en   (req && !hit),
    .line (wl_d)
  );

  // next state for spare lines
  always_comb begin
    sp_d = req ? sel : '0;
  end

  // clock enable: update on a request or to clear active lines
  assign upd_en = req || (|wl_q) || (|sp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wl_q <= '0;
      sp_q <= '0;
    end else if (upd_en) begin
      wl_q <= wl_d;
      sp_q <= sp_d;
    end
  end

  assign wl       = wl_q;
  assign spare_wl = sp_q;

  mrr_col_shift #(.W(DATA_W)) u_col (
    .fuse      (col_fuse),
    .wdata_in  (wr_data),
    .wdata_out (arr_wdata),
    .rdata_in  (arr_rdata),
    .rdata_out (rd_data)
  );

  assign spare_col_we = wr_req && col_fuse[DATA_W-1];
endmodule

// File: rtl/mem_repair_map_chk.sv
module mem_repair_map_chk #(
  parameter int unsigned ROW_AW  = 8,
  parameter int unsigned N_SPARE = 2,
  parameter int unsigned DATA_W  = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      rd_req,
  input logic                      wr_req,
  input logic [ROW_AW-1:0]         row_addr,
  input logic [N_SPARE*ROW_AW-1:0] rep_addr,
  input logic [N_SPARE-1:0]        rep_vld,
  input logic [DATA_W-1:0]         col_fuse,
  input logic [DATA_W:0]           arr_rdata,
  input logic [DATA_W-1:0]         rd_data,
  input logic                      spare_col_we,
  input logic [(1<<ROW_AW)-1:0]    wl,
  input logic [N_SPARE-1:0]        spare_wl
);
  logic any_match;
  logic e0_match;

  always_comb begin
    any_match = 1'b0;
    for (int k = 0; k < N_SPARE; k++) begin
      if (rep_vld[k] && rep_addr[k*ROW_AW +: ROW_AW] == row_addr) any_match = 1'b1;
    end
    e0_match = rep_vld[0] && (rep_addr[ROW_AW-1:0] == row_addr);
  end

  // R6
  one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({spare_wl, wl}));

  // R2
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req || wr_req) |=> (wl == '0) && (spare_wl == '0));

  // R1
  normal_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_req || wr_req) && !any_match) |=> wl[$past(row_addr)] && (spare_wl == '0));

  // R3
  spare_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_req || wr_req) && e0_match) |=> spare_wl[0] && (wl == '0));

  // R9
  no_spare_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_fuse == '0) |-> !spare_col_we && (rd_data == arr_rdata[DATA_W-1:0]));
endmodule

bind mem_repair_map mem_repair_map_chk #(
  .ROW_AW(ROW_AW), .N_SPARE(N_SPARE), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
  .row_addr(row_addr), .rep_addr(rep_addr), .rep_vld(rep_vld),
  .col_fuse(col_fuse), .arr_rdata(arr_rdata), .rd_data(rd_data),
  .spare_col_we(spare_col_we), .wl(wl), .spare_wl(spare_wl)
);

// File: tb/mem_repair_map_tb_top.sv
module mem_repair_map_tb_top;
  localparam int  AW    = 8;
  localparam int  NS    = 2;
  localparam int  W     = 8;
  localparam int  NL    = 1 << AW;
  localparam time CLK_P = 10ns;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            rd_req, wr_req;
  logic [AW-1:0]   row_addr;
  logic [NS*AW-1:0] rep_addr;
  logic [NS-1:0]   rep_vld;
  logic [W-1:0]    col_fuse;
  logic [W-1:0]    wr_data;
  logic [W:0]      arr_wdata;
  logic            spare_col_we;
  logic [W:0]      arr_rdata;
  logic [W-1:0]    rd_data;
  logic [NL-1:0]   wl;
  logic [NS-1:0]   spare_wl;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_P/2) clk = ~clk;

  mem_repair_map #(.ROW_AW(AW), .N_SPARE(NS), .DATA_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
    .row_addr(row_addr), .rep_addr(rep_addr), .rep_vld(rep_vld),
    .col_fuse(col_fuse), .wr_data(wr_data), .arr_wdata(arr_wdata),
    .spare_col_we(spare_col_we), .arr_rdata(arr_rdata), .rd_data(rd_data),
    .wl(wl), .spare_wl(spare_wl)
  );

  task automatic chk(input bit ok, input string req, input logic [NL-1:0] act,
                     input logic [NL-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NL-1:0] line_of(input logic [AW-1:0] a);
    logic [NL-1:0] v;
    v = '0;
    v[a] = 1'b1;
    return v;
  endfunction

  // request at one negedge, check lines at the next
  task automatic row_access(input logic [AW-1:0] a, input bit wr,
                            input logic [NL-1:0] exp_wl, input logic [NS-1:0] exp_sp,
                            input string req);
    row_addr = a; rd_req = !wr; wr_req = wr;
    @(negedge clk);
    rd_req = 1'b0; wr_req = 1'b0;
    chk(wl == exp_wl, {req, " wl"}, wl, exp_wl);
    chk(spare_wl == exp_sp, {req, " spare_wl"}, NL'(spare_wl), NL'(exp_sp));
  endtask

  task automatic t_reset;
    // R11
    chk(wl == '0 && spare_wl == '0, "R11 reset", wl, '0);
  endtask

  task automatic t_normal;
    rep_vld = '0;
    row_access(8'h00, 0, line_of(8'h00), '0, "R1 addr00");
    row_access(8'hFF, 1, line_of(8'hFF), '0, "R1 addrFF");
    row_access(8'h5A, 0, line_of(8'h5A), '0, "R1 addr5A");
  endtask

  task automatic t_idle;
    row_access(8'h12, 0, line_of(8'h12), '0, "R1 pre-idle");
    @(negedge clk);
    // R2
    chk(wl == '0 && spare_wl == '0, "R2 idle", wl, '0);
  endtask

  task automatic t_spare;
    rep_addr = {8'h20, 8'h10}; rep_vld = 2'b11;
    row_access(8'h20, 0, '0, 2'b10, "R3 entry1");
    row_access(8'h10, 1, '0, 2'b01, "R3 entry0");
    row_access(8'h11, 0, line_of(8'h11), '0, "R6 near miss");
  endtask

  task automatic t_invalid;
    rep_addr = {8'h20, 8'h33}; rep_vld = 2'b10;
    row_access(8'h33, 0, line_of(8'h33), '0, "R4 invalid entry");
  endtask

  task automatic t_dup;
    rep_addr = {8'h44, 8'h44}; rep_vld = 2'b11;
    row_access(8'h44, 1, '0, 2'b01, "R5 duplicate");
    rep_vld = 2'b10;
    row_access(8'h44, 0, '0, 2'b10, "R5 only upper valid");
  endtask

  function automatic logic [W:0] exp_write(input int b, input logic [W-1:0] d);
    logic [W:0] v;
    for (int j = 0; j < W; j++) begin
      if (j < b)       v[j] = d[j];
      else if (j == b) v[j] = 1'b0;
      else             v[j] = d[j-1];
    end
    v[W] = (b < W) ? d[W-1] : 1'b0;
    return v;
  endfunction

  task automatic t_col_none;
    col_fuse = '0; wr_data = 8'hA5; wr_req = 1'b1;
    #1;
    chk(arr_wdata == 9'h0A5, "R9 passthrough write", NL'(arr_wdata), NL'(9'h0A5));
    chk(spare_col_we == 1'b0, "R9 spare we", NL'(spare_col_we), '0);
    wr_req = 1'b0;
    arr_rdata = 9'h13C; #1;
    chk(rd_data == 8'h3C, "R9 spare ignored 1", NL'(rd_data), NL'(8'h3C));
    arr_rdata = 9'h03C; #1;
    chk(rd_data == 8'h3C, "R9 spare ignored 0", NL'(rd_data), NL'(8'h3C));
    @(negedge clk);
  endtask

  task automatic t_col_repair(input int b, input logic [W-1:0] d);
    logic [W:0] ew;
    logic [W:0] arr;
    logic [W-1:0] er;
    col_fuse = 8'hFF << b; wr_data = d; wr_req = 1'b1;
    #1;
    ew = exp_write(b, d);
    // R7
    chk(arr_wdata == ew, $sformatf("R7 write b=%0d", b), NL'(arr_wdata), NL'(ew));
    chk(spare_col_we == 1'b1, $sformatf("R7 spare we b=%0d", b), NL'(spare_col_we), NL'(1));
    wr_req = 1'b0;
    // R10 loopback
    arr_rdata = arr_wdata; #1;
    chk(rd_data == d, $sformatf("R10 roundtrip b=%0d", b), NL'(rd_data), NL'(d));
    // R8 read with independent array contents; bad column holds 1
    arr = {~d[W-1], d};
    arr[b] = 1'b1;
    for (int i = 0; i < W; i++) er[i] = (i < b) ? arr[i] : arr[i+1];
    arr_rdata = arr; #1;
    chk(rd_data == er, $sformatf("R8 read b=%0d", b), NL'(rd_data), NL'(er));
    @(negedge clk);
  endtask

  task automatic t_row_with_col;
    // R6 row hit while a column repair is active
    col_fuse = 8'hF0; wr_data = 8'h96;
    rep_addr = {8'h77, 8'h01}; rep_vld = 2'b11;
    row_access(8'h77, 1, '0, 2'b10, "R6 row hit with col repair");
    col_fuse = '0;
  endtask

  initial begin
    rst_n = 1'b0; rd_req = 1'b0; wr_req = 1'b0; row_addr = '0;
    rep_addr = '0; rep_vld = '0; col_fuse = '0; wr_data = '0; arr_rdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_normal();
    t_idle();
    t_spare();
    t_invalid();
    t_dup();
    t_col_none();
    t_col_repair(0, 8'hC3);
    t_col_repair(3, 8'h5A);
    t_col_repair(7, 8'h81);
    t_row_with_col();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule